// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block holds the 12-bit fetch address of a small 8-bit controller whose 4K program store is split into a lower and an upper 2K bank. Each cycle it receives the decoded strobes of the instruction that executes in that cycle. These are a sequential step, a bank selection, a jump, a call, a plain return or a return that ends an interrupt. It also receives an 11-bit branch target and two interrupt requests. From these it works out the next fetch address. It drives the push and pop side of an external return-address stack.

Choosing a bank writes only a pending flag. The upper address bit takes the flag's value at the next jump or call, so a selection can sit for any number of instructions before it has an effect. A sequential step never carries into the upper bit, so the address wraps inside its own 2K bank. While an interrupt routine runs, the upper bit is held low.

Top module: `banked_pc_seq`

## Requirements
- R1: After reset, fetchAddr is 0x000, bankFlag is 0, no interrupt is in service, and neither stack strobe is asserted.
- R2: selBank1 sets bankFlag and selBank0 clears it, both from the next cycle on. Both count as sequential steps, and neither changes fetchAddr[11].
- R3: A sequential step (advance, selBank1 or selBank0) adds one to fetchAddr[10:0] and leaves bit 11 unchanged. The address wraps from 0x7FF to 0x000 and from 0xFFF to 0x800.
- R4: A jump loads fetchAddr with {bankFlag, brTarget}.
- R5: A bank selection made several instructions earlier changes nothing until the next jump or call, which then picks up the new bankFlag.
- R6: A call pushes the 12-bit address of the next sequential instruction, which wraps within the bank. It loads fetchAddr with {bankFlag, brTarget}.
- R7: A return pops a full 12-bit address into fetchAddr, so a call can cross the bank boundary and come back. bankFlag is not changed by a return.
- R8: An interrupt is accepted only in a cycle that is a sequential step. On acceptance the block pushes the address of the next sequential instruction and vectors to 0x003 for bufIrq or 0x007 for tmrIrq. bufIrq wins when both are asserted.
- R9: While an interrupt is in service, fetchAddr[11] stays 0 through jumps, calls and returns. A bank selection in that time updates only bankFlag.
- R10: An interrupt request made while another one is in service is ignored.
- R11: A restoring return (doRetr) pops the full 12-bit address and ends the service state in the same cycle. A later request is then accepted again.
- R12: An interrupt request in a jump, call or return cycle does not disturb that instruction. It is accepted at the next sequential step instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Plain sequential instruction |
| selBank1 | input | 1 | Select upper bank (sequential) |
| selBank0 | input | 1 | Select lower bank (sequential) |
| doJump | input | 1 | Jump instruction |
| doCall | input | 1 | Call instruction |
| doRet | input | 1 | Plain return |
| doRetr | input | 1 | Return ending an interrupt routine |
| bufIrq | input | 1 | Host buffer interrupt request |
| tmrIrq | input | 1 | Timer interrupt request |
| brTarget | input | 11 | Branch target within a bank |
| stackPopData | input | 12 | Top entry of the return stack |
| stackPushEn | output | 1 | Push strobe to the return stack |
| stackPushData | output | 12 | Address to push |
| stackPopEn | output | 1 | Pop strobe to the return stack |
| fetchAddr | output | 12 | Current fetch address |
| bankFlag | output | 1 | Pending bank flag |

## Verification
An interrupt request and a branch can land in the same cycle. The bench holds bufIrq high during a call to an upper-bank target. It then expects the call to complete first, with the interrupt vectoring only on the following sequential step. The return chain that follows must come back through both stacked addresses in order. The same-cycle pairing of the two requests is also driven, and only the buffer vector is expected.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    NX_HOLD,
    NX_INC,
    NX_BRANCH,
    NX_RESTORE,
    NX_VECTOR
  } nxtSel_e;

  typedef struct packed {
    nxtSel_e sel;
    logic    bankBit;
    logic    forceLow;
    logic    vecHi;
    logic    push;
  } pcCtl_t;
endpackage

// File: rtl/bpc_ctrl.sv
module bpc_ctrl
  import bpc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   advance,
  input  logic   selBank1,
  input  logic   selBank0,
  input  logic   doJump,
  input  logic   doCall,
  input  logic   doRet,
  input  logic   doRetr,
  input  logic   bufIrq,
  input  logic   tmrIrq,
  input  logic   pcHigh,
  output pcCtl_t ctl,
  output logic   bankFlag,
  output logic   popEn
);
  logic bankFf;
  logic inService;
  logic seqStep;
  logic irqTake;

  assign seqStep = advance | selBank1 | selBank0;
  assign irqTake = seqStep & ~inService & (bufIrq | tmrIrq);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankFf    <= 1'b0;
      inService <= 1'b0;
    end else begin
      if (selBank1)      bankFf <= 1'b1;
      else if (selBank0) bankFf <= 1'b0;
      if (doRetr)        inService <= 1'b0;
      else if (irqTake)  inService <= 1'b1;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.bankBit  = bankFf;
    ctl.vecHi    = ~bufIrq;
    ctl.forceLow = inService & ~doRetr;
    if (doRetr || doRet)  ctl.sel = NX_RESTORE;
    else if (doCall)      ctl.sel = NX_BRANCH;
    else if (doJump)      ctl.sel = NX_BRANCH;
    else if (irqTake)     ctl.sel = NX_VECTOR;
    else if (seqStep)     ctl.sel = NX_INC;
    else                  ctl.sel = NX_HOLD;
    ctl.push = (doCall & ~doRet & ~doRetr) | (irqTake & ~doJump & ~doCall & ~doRet & ~doRetr);
  end

  assign bankFlag = bankFf;
  assign popEn    = doRet | doRetr;

  // R9
  isr_bank_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    inService |-> !pcHigh);

  // R7
  ret_keeps_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doRet && !selBank1 && !selBank0) |=> bankFf == $past(bankFf));

  // R10
  no_nest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inService && !doRetr) |=> inService);
endmodule

// File: rtl/bpc_path.sv
module bpc_path
  import bpc_pkg::*;
#(
  parameter int PC_W    = 12,
  parameter int VEC_BUF = 3,
  parameter int VEC_TMR = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  pcCtl_t          ctl,
  input  logic [PC_W-2:0] brTarget,
  input  logic [PC_W-1:0] popData,
  output logic [PC_W-1:0] pushData,
  output logic [PC_W-1:0] pc
);
  localparam int LOW_W = PC_W - 1;

  logic [PC_W-1:0]  pcReg;
  logic [PC_W-1:0]  incAddr;
  logic [PC_W-1:0]  nxtRaw;
  logic [PC_W-1:0]  nxtPc;
  logic [LOW_W-1:0] lowInc;

  assign lowInc  = pcReg[LOW_W-1:0] + 1'b1;
  assign incAddr = {pcReg[PC_W-1], lowInc};

  always_comb begin
    case (ctl.sel)
      NX_INC:     nxtRaw = incAddr;
      NX_BRANCH:  nxtRaw = {ctl.bankBit, brTarget};
      NX_RESTORE: nxtRaw = popData;
      NX_VECTOR:  nxtRaw = ctl.vecHi ? PC_W'(VEC_TMR) : PC_W'(VEC_BUF);
      default:    nxtRaw = pcReg;
    endcase
    nxtPc = nxtRaw;
    if (ctl.forceLow || ctl.sel == NX_VECTOR) nxtPc[PC_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pcReg <= '0;
    else       pcReg <= nxtPc;
  end

  assign pc       = pcReg;
  assign pushData = incAddr;

  // R3
  inc_in_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == NX_INC) |=> (pcReg[PC_W-1] == $past(pcReg[PC_W-1]))
                            && (pcReg[LOW_W-1:0] == $past(pcReg[LOW_W-1:0]) + 1'b1));

  // R4
  branch_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == NX_BRANCH && !ctl.forceLow) |=> pcReg[PC_W-1] == $past(ctl.bankBit));

  // R8
  vector_loc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sel == NX_VECTOR) |=> (pcReg == PC_W'(VEC_BUF) || pcReg == PC_W'(VEC_TMR)));
endmodule

// File: rtl/banked_pc_seq.sv
module banked_pc_seq
  import bpc_pkg::*;
#(
  parameter int PC_W    = 12,
  parameter int VEC_BUF = 3,
  parameter int VEC_TMR = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            advance,
  input  logic            selBank1,
  input  logic            selBank0,
  input  logic            doJump,
  input  logic            doCall,
  input  logic            doRet,
  input  logic            doRetr,
  input  logic            bufIrq,
  input  logic            tmrIrq,
  input  logic [PC_W-2:0] brTarget,
  input  logic [PC_W-1:0] stackPopData,
  output logic            stackPushEn,
  output logic [PC_W-1:0] stackPushData,
  output logic            stackPopEn,
  output logic [PC_W-1:0] fetchAddr,
  output logic            bankFlag
);
  pcCtl_t ctl;

  bpc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .advance(advance), .selBank1(selBank1),
    .selBank0(selBank0), .doJump(doJump), .doCall(doCall), .doRet(doRet),
    .doRetr(doRetr), .bufIrq(bufIrq), .tmrIrq(tmrIrq),
    .pcHigh(fetchAddr[PC_W-1]), .ctl(ctl), .bankFlag(bankFlag),
    .popEn(stackPopEn)
  );

  bpc_path #(.PC_W(PC_W), .VEC_BUF(VEC_BUF), .VEC_TMR(VEC_TMR)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .brTarget(brTarget),
    .popData(stackPopData), .pushData(stackPushData), .pc(fetchAddr)
  );

  assign stackPushEn = ctl.push;
endmodule

// File: tb/banked_pc_seq_bench.sv
module banked_pc_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        advance = 0, selBank1 = 0, selBank0 = 0, doJump = 0, doCall = 0;
  logic        doRet = 0, doRetr = 0, bufIrq = 0, tmrIrq = 0;
  logic [10:0] brTarget = '0;
  logic [11:0] stackPopData;
  logic        stackPushEn, stackPopEn, bankFlag;
  logic [11:0] stackPushData, fetchAddr;

  int applied = 0;
  int failed  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_pc_seq u_banked_pc_seq (
    .clk(clk), .rstN(rstN), .advance(advance), .selBank1(selBank1),
    .selBank0(selBank0), .doJump(doJump), .doCall(doCall), .doRet(doRet),
    .doRetr(doRetr), .bufIrq(bufIrq), .tmrIrq(tmrIrq), .brTarget(brTarget),
    .stackPopData(stackPopData), .stackPushEn(stackPushEn),
    .stackPushData(stackPushData), .stackPopEn(stackPopEn),
    .fetchAddr(fetchAddr), .bankFlag(bankFlag)
  );

  // behavioural return stack
  logic [11:0] stk [16];
  int sp = 0;
  assign stackPopData = (sp > 0) ? stk[sp-1] : 12'h000;
  always @(posedge clk) begin
    if (rstN && stackPushEn) begin
      stk[sp] <= stackPushData;
      sp <= sp + 1;
    end else if (rstN && stackPopEn && sp > 0) begin
      sp <= sp - 1;
    end
  end

  typedef struct {
    logic [11:0] addr;
    logic        bank;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  // reference model state
  logic [11:0] mPc = '0;
  logic        mBank = 1'b0;
  logic        mIsr = 1'b0;
  logic [11:0] mStk [16];
  int          mSp = 0;

  typedef enum int {K_IDLE, K_ADV, K_SEL1, K_SEL0, K_JMP, K_CALL, K_RET, K_RETR} kind_e;

  task automatic step(input kind_e k, input logic [10:0] tgt, input logic bI,
                      input logic tI, input string tag);
    logic [11:0] inc, nxt;
    logic seq, take;
    @(negedge clk);
    advance  = (k == K_ADV);  selBank1 = (k == K_SEL1); selBank0 = (k == K_SEL0);
    doJump   = (k == K_JMP);  doCall   = (k == K_CALL); doRet    = (k == K_RET);
    doRetr   = (k == K_RETR); bufIrq   = bI;           tmrIrq   = tI;
    brTarget = tgt;
    inc  = {mPc[11], mPc[10:0] + 11'd1};
    seq  = (k == K_ADV) || (k == K_SEL1) || (k == K_SEL0);
    take = seq && !mIsr && (bI || tI);
    case (k)
      K_ADV, K_SEL1, K_SEL0: nxt = inc;
      K_JMP:  nxt = {mBank, tgt};
      K_CALL: begin mStk[mSp] = inc; mSp++; nxt = {mBank, tgt}; end
      K_RET, K_RETR: begin mSp--; nxt = mStk[mSp]; end
      default: nxt = mPc;
    endcase
    if (mIsr && k != K_RETR) nxt[11] = 1'b0;
    if (k == K_SEL1) mBank = 1'b1;
    if (k == K_SEL0) mBank = 1'b0;
    if (k == K_RETR) mIsr = 1'b0;
    if (take) begin
      mStk[mSp] = inc; mSp++;
      nxt = bI ? 12'h003 : 12'h007;
      mIsr = 1'b1;
    end
    mPc = nxt;
    expQ.push_back('{addr: nxt, bank: mBank, tag: tag});
  endtask

  // monitor: compare one expectation per cycle, one time unit after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        applied++;
        if (fetchAddr !== e.addr || bankFlag !== e.bank) begin
          failed++;
          $display("FAIL %s: fetchAddr=%h bankFlag=%b expected %h / %b",
                   e.tag, fetchAddr, bankFlag, e.addr, e.bank);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    failed++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    applied++;
    if (fetchAddr !== 12'h000 || bankFlag !== 1'b0 || stackPushEn !== 1'b0 || stackPopEn !== 1'b0) begin
      failed++;
      $display("FAIL R1: fetchAddr=%h bank=%b push=%b pop=%b expected 000/0/0/0",
               fetchAddr, bankFlag, stackPushEn, stackPopEn);
    end
    @(negedge clk); rstN = 1'b1;

    step(K_ADV,  11'h0, 0, 0, "R3 seq");
    step(K_ADV,  11'h0, 0, 0, "R3 seq");
    step(K_ADV,  11'h0, 0, 0, "R3 seq");
    step(K_SEL1, 11'h0, 0, 0, "R2 select upper");
    step(K_ADV,  11'h0, 0, 0, "R5 pending");
    step(K_ADV,  11'h0, 0, 0, "R5 pending");
    step(K_JMP,  11'h100, 0, 0, "R4 R5 jump applies bank");
    step(K_ADV,  11'h0, 0, 0, "R3 seq upper");
    step(K_JMP,  11'h7FF, 0, 0, "R4 jump top");
    step(K_ADV,  11'h0, 0, 0, "R3 wrap upper");
    step(K_CALL, 11'h010, 0, 0, "R6 call");
    step(K_SEL0, 11'h0, 0, 0, "R2 select lower");
    step(K_RET,  11'h0, 0, 0, "R7 return keeps bank");
    step(K_JMP,  11'h7FE, 0, 0, "R4 jump lower");
    step(K_ADV,  11'h0, 0, 0, "R3 seq");
    step(K_ADV,  11'h0, 0, 0, "R3 wrap lower");
    step(K_SEL1, 11'h0, 0, 0, "R2 select upper");
    step(K_JMP,  11'h400, 0, 0, "R4 jump upper");
    step(K_ADV,  11'h0, 1, 1, "R8 both requests buffer wins");
    step(K_ADV,  11'h0, 0, 1, "R10 ignored in service");
    step(K_SEL1, 11'h0, 0, 0, "R9 select in service");
    step(K_JMP,  11'h020, 0, 0, "R9 jump held low");
    step(K_CALL, 11'h040, 0, 0, "R9 call held low");
    step(K_RET,  11'h0, 0, 0, "R9 return in service");
    step(K_RETR, 11'h0, 0, 0, "R11 restoring return");
    step(K_CALL, 11'h050, 1, 0, "R12 call beats request");
    step(K_ADV,  11'h0, 1, 0, "R12 deferred vector");
    step(K_RETR, 11'h0, 0, 0, "R11 return to callee");
    step(K_RET,  11'h0, 0, 0, "R6 R7 cross bank return");
    step(K_ADV,  11'h0, 0, 1, "R8 timer vector");
    step(K_RETR, 11'h0, 0, 0, "R11 restore after timer");
    step(K_IDLE, 11'h0, 0, 0, "R3 idle hold");

    @(negedge clk);
    advance = 0; selBank1 = 0; selBank0 = 0; doJump = 0; doCall = 0;
    doRet = 0; doRetr = 0; bufIrq = 0; tmrIrq = 0;
    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule